// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Sequencer

This block sits between a synchronous host and an external asynchronous static RAM. The RAM is byte-wide with a 17-bit address. It has an active-low and an active-high chip select, an active-low output enable and an active-low write strobe. The host raises a request carrying an address, a write byte and a direction flag. The sequencer then plays out one complete memory cycle on the pins. It signals completion with a single-cycle acknowledge and, for reads, leaves the fetched byte in a register.

Every analog timing limit of the memory is a nanosecond parameter. Together with the clock period, the block turns each limit into a whole number of clock cycles by rounding up. Where the memory needs a nonzero margin, the block applies a floor of one cycle. The data bus is split into an output byte, an output enable and an input byte, so the pad ring supplies the tristate buffer.

Between cycles the chip is deselected. The output enable and write strobe stay high, and the controller's bus driver is off. The host can see from `host_ready` when the next request will be taken.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: While `host_ready` is high, both chip selects are inactive (`mem_sel_n`=1, `mem_sel`=0), `mem_oe_n`=1, `mem_we_n`=1 and `mem_dq_drive`=0. This is also the state after reset.
- R2: A read keeps the chip selected with `mem_oe_n`=0 and `mem_we_n`=1 for RD_CYC cycles, where RD_CYC is the largest of the read cycle, address access and output-enable access times in cycles (4 at default). `host_rdata` takes `mem_dq_in` on the clock edge that ends this count.
- R3: A write holds `mem_we_n` low for exactly WP_CYC consecutive cycles while driving the write byte, with `mem_oe_n` high throughout. WP_CYC covers the write pulse, the data setup and the address-to-end-of-write time (3 at default).
- R4: Whenever `mem_we_n` is low, the chip is selected and `mem_addr` does not change. Address and selects are applied at least one cycle before `mem_we_n` falls.
- R5: `mem_dq_drive` is high only while `mem_we_n` is low or in the single hold cycle that follows it. It is never high while `mem_oe_n` is low.
- R6: Each accepted request produces exactly one `host_ack` pulse of one cycle. Counted in clock edges from the accepting edge, the pulse comes 1+WP_CYC+1 edges later for a write (5 at default) and RD_CYC edges later for a read (4 at default).
- R7: A request raised while `host_ready` is low is ignored and leaves the memory contents untouched.
- R8: After each operation the chip stays deselected before `host_ready` returns. The deselect lasts the output-disable time in cycles after a read (2 at default) and the remainder of the write cycle time, at least one cycle, after a write (1 at default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req | input | 1 | Request strobe, taken when host_ready is high |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 17 | Byte address |
| host_wdata | input | 8 | Write byte |
| host_ready | output | 1 | Sequencer idle, a request is taken this cycle |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | 8 | Byte captured by the last read |
| mem_addr | output | 17 | Address pins |
| mem_sel_n | output | 1 | Active-low chip select |
| mem_sel | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_dq_out | output | 8 | Byte driven onto the data bus |
| mem_dq_drive | output | 1 | Enable of the controller's bus driver |
| mem_dq_in | input | 8 | Byte read from the data bus |

## Verification
The embedded assertions assume a few things about the environment. The memory returns a settled byte on `mem_dq_in` by the end of the read count. The host only counts on a request being taken while `host_ready` is high. The pin rules themselves (stable address under a low strobe, no drive against an enabled memory) are checked unconditionally. The bench pairs the sequencer with a behavioural memory that answers only when selected with the output enable low and the strobe high, and stores only on a selected strobe-low cycle with the driver on. The stimulus comes from a fixed-seed random mix of reads and writes over a small address pool that includes both ends of the address range. Some requests are deliberately raised while the sequencer is busy. These must have no effect, so the bench reads their target addresses back later.

// File: rtl/sram_ctrl_pkg.sv
// Shared types and helpers for the SRAM cycle sequencer.
// Assumes all timing values are non-negative integers in nanoseconds.
package sram_ctrl_pkg;

    // Sequencer phases; one memory cycle walks a fixed path through these.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_WSET  = 3'd1,
        ST_WPUL  = 3'd2,
        ST_WHLD  = 3'd3,
        ST_WGAP  = 3'd4,
        ST_RACC  = 3'd5,
        ST_ROFF  = 3'd6
    } seq_st_t;

    // Round a nanosecond interval up to whole clock periods.
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    // Larger of two integers.
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
// Loadable down-counter that times one sequencer phase.
// Assumes load values fit CNT_W bits; zero is flagged combinationally.
module sram_phase_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);

    logic [CNT_W-1:0] cnt_q;

    // Count down to zero, restart on load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

    // R6 support: an idle counter never wraps below zero.
    a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && zero) |=> zero);

endmodule

// File: rtl/sram_seq.sv
// Phase sequencer: accepts a host request in idle and steps through
// setup, strobe, hold and deselect phases using the phase timer.
// Assumes every *_CYC parameter is at least 1.
module sram_seq
    import sram_ctrl_pkg::*;
#(
    parameter int SU_CYC   = 1,
    parameter int WP_CYC   = 3,
    parameter int HOLD_CYC = 1,
    parameter int GAP_CYC  = 1,
    parameter int RD_CYC   = 4,
    parameter int ROFF_CYC = 2
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    req,
    input  logic    req_write,
    output seq_st_t state_q,
    output seq_st_t state_nxt,
    output logic    accept,
    output logic    capture,
    output logic    ack_set
);

    localparam int MAX_CYC = imax(imax(imax(SU_CYC, WP_CYC), imax(HOLD_CYC, GAP_CYC)),
                                  imax(RD_CYC, ROFF_CYC));
    localparam int CNT_W   = $clog2(MAX_CYC) + 1;

    localparam logic [CNT_W-1:0] LD_SU   = CNT_W'(SU_CYC - 1);
    localparam logic [CNT_W-1:0] LD_WP   = CNT_W'(WP_CYC - 1);
    localparam logic [CNT_W-1:0] LD_HOLD = CNT_W'(HOLD_CYC - 1);
    localparam logic [CNT_W-1:0] LD_GAP  = CNT_W'(GAP_CYC - 1);
    localparam logic [CNT_W-1:0] LD_RD   = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] LD_ROFF = CNT_W'(ROFF_CYC - 1);

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_zero;

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    // Next phase, timer reload and event strobes.
    always_comb begin
        state_nxt = state_q;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        accept    = 1'b0;
        capture   = 1'b0;
        ack_set   = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (req) begin
                    accept   = 1'b1;
                    tmr_load = 1'b1;
                    if (req_write) begin
                        state_nxt = ST_WSET;
                        tmr_val   = LD_SU;
                    end else begin
                        state_nxt = ST_RACC;
                        tmr_val   = LD_RD;
                    end
                end
            end
            ST_WSET: if (tmr_zero) begin
                state_nxt = ST_WPUL;
                tmr_load  = 1'b1;
                tmr_val   = LD_WP;
            end
            ST_WPUL: if (tmr_zero) begin
                state_nxt = ST_WHLD;
                tmr_load  = 1'b1;
                tmr_val   = LD_HOLD;
            end
            ST_WHLD: if (tmr_zero) begin
                state_nxt = ST_WGAP;
                tmr_load  = 1'b1;
                tmr_val   = LD_GAP;
                ack_set   = 1'b1;
            end
            ST_WGAP: if (tmr_zero) begin
                state_nxt = ST_IDLE;
            end
            ST_RACC: if (tmr_zero) begin
                state_nxt = ST_ROFF;
                tmr_load  = 1'b1;
                tmr_val   = LD_ROFF;
                capture   = 1'b1;
                ack_set   = 1'b1;
            end
            ST_ROFF: if (tmr_zero) begin
                state_nxt = ST_IDLE;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nxt;
    end

    // R6: the completion strobe never lasts two cycles.
    a_r6_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        ack_set |=> !ack_set);

    // R7: an operation can only start from idle.
    a_r7_start_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_WSET || state_q == ST_RACC) && $past(state_q) != state_q)
        |-> $past(state_q) == ST_IDLE);

endmodule

// File: rtl/sram_pin_drv.sv
// Pin driver: registers every memory pin from the next phase so that the
// strobes are glitch-free, holds address and write byte for the whole cycle,
// and captures the read byte.
// Assumes the memory data is settled when capture is raised.
module sram_pin_drv
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  seq_st_t           state_nxt,
    input  logic              accept,
    input  logic              capture,
    input  logic              ack_set,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] dq_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_sel_n,
    output logic              mem_sel,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_drive,
    output logic [DATA_W-1:0] rdata,
    output logic              ack
);

    logic sel_nxt;
    assign sel_nxt = (state_nxt == ST_WSET) || (state_nxt == ST_WPUL) ||
                     (state_nxt == ST_WHLD) || (state_nxt == ST_RACC);

    // Latch address and write byte when a request is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr <= '0;
            dq_out   <= '0;
        end else if (accept) begin
            mem_addr <= req_addr;
            dq_out   <= req_wdata;
        end
    end

    // Control strobes decoded from the coming phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_sel_n <= 1'b1;
            mem_sel   <= 1'b0;
            mem_oe_n  <= 1'b1;
            mem_we_n  <= 1'b1;
            dq_drive  <= 1'b0;
        end else begin
            mem_sel_n <= !sel_nxt;
            mem_sel   <= sel_nxt;
            mem_oe_n  <= (state_nxt != ST_RACC);
            mem_we_n  <= (state_nxt != ST_WPUL);
            dq_drive  <= (state_nxt == ST_WPUL) || (state_nxt == ST_WHLD);
        end
    end

    // Read capture and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
            ack   <= 1'b0;
        end else begin
            if (capture) rdata <= dq_in;
            ack <= ack_set;
        end
    end

    // R3: output enable stays high under a low write strobe.
    a_r3_oe_high_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n);

    // R4: chip is selected whenever the write strobe is low.
    a_r4_sel_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_sel_n && mem_sel));

    // R4: address holds across a low write strobe.
    a_r4_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && !$past(mem_we_n)) |-> $stable(mem_addr));

    // R4: the strobe falls only after a cycle with the chip already selected.
    a_r4_setup_before_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> !$past(mem_sel_n));

    // R5: no drive while the memory's outputs are enabled.
    a_r5_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        !(dq_drive && !mem_oe_n));

    // R5: drive after the strobe rises lasts one hold cycle at most.
    a_r5_drive_release: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_drive && mem_we_n) |=> !dq_drive);

endmodule

// File: rtl/sram_cycle_ctrl.sv
// Top of the SRAM cycle sequencer. Converts nanosecond limits to cycle
// counts, then joins the phase sequencer and the pin driver.
// Assumes CLK_NS > 0 and one outstanding request at a time.
module sram_cycle_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W   = 17,
    parameter int DATA_W   = 8,
    parameter int CLK_NS   = 20,
    parameter int T_RC_NS  = 70,
    parameter int T_AA_NS  = 70,
    parameter int T_OE_NS  = 35,
    parameter int T_OHZ_NS = 35,
    parameter int T_WC_NS  = 70,
    parameter int T_AW_NS  = 60,
    parameter int T_WP_NS  = 45,
    parameter int T_DW_NS  = 30,
    parameter int T_AS_NS  = 0,
    parameter int T_WR_NS  = 0,
    parameter int T_DH_NS  = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_write,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_ready,
    output logic              host_ack,
    output logic [DATA_W-1:0] host_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_sel_n,
    output logic              mem_sel,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_drive,
    input  logic [DATA_W-1:0] mem_dq_in
);

    localparam int SU_CYC   = imax(1, ns_to_cyc(T_AS_NS, CLK_NS));
    localparam int WP_CYC   = imax(imax(1, ns_to_cyc(T_WP_NS, CLK_NS)),
                                   imax(ns_to_cyc(T_DW_NS, CLK_NS),
                                        ns_to_cyc(T_AW_NS, CLK_NS) - SU_CYC));
    localparam int HOLD_CYC = imax(1, imax(ns_to_cyc(T_WR_NS, CLK_NS),
                                           ns_to_cyc(T_DH_NS, CLK_NS)));
    localparam int GAP_CYC  = imax(1, ns_to_cyc(T_WC_NS, CLK_NS) - SU_CYC - WP_CYC - HOLD_CYC);
    localparam int RD_CYC   = imax(1, imax(ns_to_cyc(T_RC_NS, CLK_NS),
                                           imax(ns_to_cyc(T_AA_NS, CLK_NS),
                                                ns_to_cyc(T_OE_NS, CLK_NS))));
    localparam int ROFF_CYC = imax(1, ns_to_cyc(T_OHZ_NS, CLK_NS));

    seq_st_t state_q;
    seq_st_t state_nxt;
    logic    accept;
    logic    capture;
    logic    ack_set;

    sram_seq #(
        .SU_CYC   (SU_CYC),
        .WP_CYC   (WP_CYC),
        .HOLD_CYC (HOLD_CYC),
        .GAP_CYC  (GAP_CYC),
        .RD_CYC   (RD_CYC),
        .ROFF_CYC (ROFF_CYC)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (host_req),
        .req_write (host_write),
        .state_q   (state_q),
        .state_nxt (state_nxt),
        .accept    (accept),
        .capture   (capture),
        .ack_set   (ack_set)
    );

    sram_pin_drv #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_pins (
        .clk       (clk),
        .rst_n     (rst_n),
        .state_nxt (state_nxt),
        .accept    (accept),
        .capture   (capture),
        .ack_set   (ack_set),
        .req_addr  (host_addr),
        .req_wdata (host_wdata),
        .dq_in     (mem_dq_in),
        .mem_addr  (mem_addr),
        .mem_sel_n (mem_sel_n),
        .mem_sel   (mem_sel),
        .mem_oe_n  (mem_oe_n),
        .mem_we_n  (mem_we_n),
        .dq_out    (mem_dq_out),
        .dq_drive  (mem_dq_drive),
        .rdata     (host_rdata),
        .ack       (host_ack)
    );

    assign host_ready = (state_q == ST_IDLE);

    // R1: an idle sequencer leaves the memory deselected and the bus free.
    a_r1_idle_pins: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |-> (mem_sel_n && !mem_sel && mem_oe_n && mem_we_n && !mem_dq_drive));

    // R8: the acknowledge cycle is always a deselected cycle.
    a_r8_ack_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |-> (mem_sel_n && !mem_sel && !host_ready));

endmodule

// File: tb/sram_cycle_ctrl_bench.sv
module sram_cycle_ctrl_bench;

    localparam int PER_NS = 20;

    function automatic int up_div(input int n);
        return (n + PER_NS - 1) / PER_NS;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Expected cycle counts from the requirements at default timing.
    localparam int E_SU   = mx(1, up_div(0));
    localparam int E_WP   = mx(mx(up_div(45), up_div(30)), up_div(60) - E_SU);
    localparam int E_HOLD = 1;
    localparam int E_GAP  = mx(1, up_div(70) - E_SU - E_WP - E_HOLD);
    localparam int E_RD   = mx(up_div(70), up_div(35));
    localparam int E_ROFF = mx(1, up_div(35));

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0;
    logic        host_write = 1'b0;
    logic [16:0] host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic        host_ready, host_ack;
    logic [7:0]  host_rdata;
    logic [16:0] mem_addr;
    logic        mem_sel_n, mem_sel, mem_oe_n, mem_we_n, mem_dq_drive;
    logic [7:0]  mem_dq_out, mem_dq_in;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    sram_cycle_ctrl u_sram_cycle_ctrl (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_write(host_write),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_ready(host_ready),
        .host_ack(host_ack), .host_rdata(host_rdata), .mem_addr(mem_addr),
        .mem_sel_n(mem_sel_n), .mem_sel(mem_sel), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out), .mem_dq_drive(mem_dq_drive),
        .mem_dq_in(mem_dq_in)
    );

    // Behavioural memory and bench shadow of expected contents.
    logic [7:0] model_mem [int];
    logic [7:0] shadow [int];

    function automatic logic [7:0] def_byte(input int a);
        return 8'(a) ^ 8'(a >> 8) ^ 8'h5A;
    endfunction
    function automatic logic [7:0] model_rd(input int a);
        if (model_mem.exists(a)) return model_mem[a];
        return def_byte(a);
    endfunction
    function automatic logic [7:0] shadow_rd(input int a);
        if (shadow.exists(a)) return shadow[a];
        return def_byte(a);
    endfunction

    assign mem_dq_in = (!mem_sel_n && mem_sel && !mem_oe_n && mem_we_n)
                       ? model_rd(int'(mem_addr)) : 8'hEE;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Pin monitor, sampled away from the active edge.
    int v_r1 = 0, v_r3 = 0, v_r4 = 0, v_r5 = 0;
    int we_run = 0, last_run = 0, ack_cnt = 0;
    logic        prev_we_low = 1'b0;
    logic [16:0] prev_addr = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!mem_sel_n && mem_sel && !mem_we_n && mem_dq_drive)
                model_mem[int'(mem_addr)] = mem_dq_out;
            if (host_ready && (!mem_sel_n || mem_sel || !mem_oe_n || !mem_we_n || mem_dq_drive))
                v_r1++;
            if (!mem_we_n && !mem_oe_n) v_r3++;
            if (!mem_we_n && (mem_sel_n || !mem_sel)) v_r4++;
            if (!mem_we_n && prev_we_low && mem_addr != prev_addr) v_r4++;
            if (mem_dq_drive && !mem_oe_n) v_r5++;
            if (mem_dq_drive && mem_we_n && !prev_we_low) v_r5++;
            if (!mem_we_n) we_run++;
            else if (prev_we_low) begin last_run = we_run; we_run = 0; end
            if (host_ack) ack_cnt++;
            prev_we_low = !mem_we_n;
            prev_addr   = mem_addr;
        end
    end

    int ops = 0;

    // One host operation with optional busy-time intrusion request.
    task automatic run_op(input bit wr, input logic [16:0] a, input logic [7:0] d,
                          input bit intrude);
        int cnt;
        int gap;
        @(negedge clk);
        chk(host_ready, "R7 ready before request", host_ready, 1);
        host_req = 1'b1; host_write = wr; host_addr = a; host_wdata = d;
        @(negedge clk);
        ops++;
        host_req = 1'b0;
        cnt = 1;
        if (intrude) begin
            host_req = 1'b1; host_write = 1'b1;
            host_addr = a ^ 17'h00100; host_wdata = ~d;
            @(negedge clk);
            cnt++;
            host_req = 1'b0;
        end
        while (!host_ack && cnt < 50) begin
            @(negedge clk);
            cnt++;
        end
        if (wr) begin
            chk(cnt == E_SU + E_WP + E_HOLD + 1, "R6 write ack latency", cnt, E_SU + E_WP + E_HOLD + 1);
            chk(last_run == E_WP, "R3 write strobe width", last_run, E_WP);
            shadow[int'(a)] = d;
        end else begin
            chk(cnt == E_RD + 1, "R6 read ack latency", cnt, E_RD + 1);
            chk(host_rdata == shadow_rd(int'(a)), "R2 read data", host_rdata, shadow_rd(int'(a)));
        end
        gap = 0;
        while (!host_ready && gap < 50) begin
            if (!mem_sel_n || mem_sel) gap = 100;
            @(negedge clk);
            gap++;
            if (gap == 2) chk(!host_ack, "R6 ack one cycle", host_ack, 0);
        end
        chk(gap == (wr ? E_GAP : E_ROFF), "R8 deselect gap", gap, wr ? E_GAP : E_ROFF);
    endtask

    logic [16:0] pool [8];

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk(mem_sel_n && !mem_sel && mem_oe_n && mem_we_n && !mem_dq_drive && !host_ack,
            "R1 pins in reset", {mem_sel_n, mem_sel, mem_oe_n, mem_we_n, mem_dq_drive}, 5'b10110);
        rst_n = 1'b1;
        @(negedge clk);
        chk(host_ready, "R1 ready after reset", host_ready, 1);

        // Directed corners: both address extremes, unwritten read, turnarounds.
        run_op(1'b0, 17'h00042, 8'h00, 1'b0);
        run_op(1'b1, 17'h00000, 8'h00, 1'b0);
        run_op(1'b1, 17'h1FFFF, 8'hFF, 1'b0);
        run_op(1'b0, 17'h00000, 8'h00, 1'b0);
        run_op(1'b0, 17'h1FFFF, 8'h00, 1'b0);
        run_op(1'b1, 17'h0A5A5, 8'h3C, 1'b1);
        run_op(1'b0, 17'h0A5A5, 8'h00, 1'b0);
        run_op(1'b0, 17'h0A4A5, 8'h00, 1'b0);   // R7 intrusion target untouched

        pool[0] = 17'h00000; pool[1] = 17'h1FFFF;
        for (int i = 2; i < 8; i++) pool[i] = 17'($urandom);
        for (int i = 0; i < 60; i++) begin
            logic [16:0] a;
            a = pool[$urandom % 8];
            run_op(1'($urandom), a, 8'($urandom), ($urandom % 5) == 0);
        end
        for (int i = 0; i < 8; i++) begin
            run_op(1'b0, pool[i], 8'h00, 1'b0);
            run_op(1'b0, pool[i] ^ 17'h00100, 8'h00, 1'b0);
        end

        @(negedge clk);
        chk(v_r1 == 0, "R1 idle pin state", v_r1, 0);
        chk(v_r3 == 0, "R3 oe high in write", v_r3, 0);
        chk(v_r4 == 0, "R4 address and select under strobe", v_r4, 0);
        chk(v_r5 == 0, "R5 bus drive window", v_r5, 0);
        chk(ack_cnt == ops, "R6 one ack per op", ack_cnt, ops);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule